// File: doc/BRIEF.md
# Asynchronous Static-Memory Bus Controller

This controller turns one request at a time from an on-chip requester into timed read or write cycles on an external bus. The bus follows the static-RAM pattern, with address and data on separate lines. Every external signal is derived from registers clocked by the system clock. The upper bits of the request address select one of four device regions, and each region drives its own active-low select line.

Each region has its own settings:
- device width of 16 or 32 bits;
- select-to-strobe delay;
- strobe length;
- whether the external ready input may stretch the strobe;
- write hold time;
- four idle-time counts, applied after a change of region, after a change of direction, after a read and after a write.

A 32-bit request to a 16-bit region becomes up to two halfword cycles. The lower halfword goes first. A halfword whose byte enables are all clear is left out.

The request side uses valid/ready. `req_ready` is high only while the controller is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester holds its fields stable until that edge. The completion side has no back-pressure. `rsp_valid` is a single-cycle pulse carrying `rsp_rdata`, and the requester must accept it in that cycle.

Top module: `async_mem_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high:
  - all selects, both strobes and all byte-lane lines are high;
  - `ext_rw` is high and `ext_doe` is low;
  - `req_ready` is high and `rsp_valid` is low.
- R2: Region selection:
  - the top two bits of `req_addr` (a word address) select region n, which drives `ext_cs_n[n]` low;
  - the remaining bits form `ext_addr[23:2]`;
  - at most one select is low at any time.
- R3: Select-to-strobe delay and strobe rules:
  - a cycle keeps its select low, with both strobes high, for exactly the region's `cfg_cmd` cycles before the strobe falls;
  - `ext_rd_n` (reads) and `ext_wr_n` (writes) are never low together, and never low while all selects are high.
- R4: A strobe lasts exactly `cfg_wait`+1 cycles when the region's wait-enable bit is clear, whatever level `ext_wait_n` has.
- R5: When the region's wait-enable bit is set:
  - `ext_wait_n` is active low and passes through a two-flop synchronizer;
  - once the programmed count has run out, a low level holds the strobe;
  - the strobe ends within five cycles after `ext_wait_n` returns high.
- R6: Write cycles:
  - `ext_rw` is low and `ext_doe` is high throughout;
  - after `ext_wr_n` rises, select, address and data stay unchanged for exactly the region's `cfg_hold` cycles.
- R7: A 32-bit region makes one cycle per request, as follows.

  | Item | Value |
  |---|---|
  | `ext_addr[1:0]` | 00 |
  | `ext_dout` | the full write word |
  | `ext_bc_n` | the inverted `req_be` |
  | read data | all 32 bits of `ext_din` |

- R8: A 16-bit region makes one cycle per halfword, as follows.

  | Item | Value |
  |---|---|
  | Order | lower halfword at `ext_addr[1:0]`=00 first, then upper halfword at `ext_addr[1:0]`=10 |
  | Data lanes | `ext_dout[15:0]` / `ext_din[15:0]` |
  | `ext_bc_n[1:0]` | the inverted byte enables of that halfword |
  | `ext_bc_n[3:2]` | high |
  | Read result | lower cycle into `rsp_rdata[15:0]`, upper cycle into `rsp_rdata[31:16]` |

- R9: In a 16-bit region:
  - a halfword whose two byte enables are clear makes no bus cycle, and its half of `rsp_rdata` is zero;
  - with all four enables clear, no bus cycle occurs but `rsp_valid` still pulses.
- R10: Idle time between cycles:
  - between one cycle's select rising and the next select falling, at least max(1, R) idle cycles pass;
  - R is the largest of the previous region's counts that apply: `cfg_rec_cs` on a region change, `cfg_rec_rw` on a direction change, and `cfg_rec_rd` or `cfg_rec_wr` after a read or a write;
  - between the halves of one split request the gap is exactly max(1, R).
- R11: Request and completion handshake:
  - `req_ready` is low from acceptance until after the completion pulse;
  - `rsp_valid` is high for exactly one cycle after the last bus cycle of a request, with the assembled read data on `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | NREGION | Per region: 1 = 32-bit device, 0 = 16-bit device |
| cfg_wait_en | input | NREGION | Per region: let `ext_wait_n` stretch the strobe |
| cfg_cmd | input | NREGION*CW | Per region: select-to-strobe cycles |
| cfg_wait | input | NREGION*CW | Per region: programmed strobe extension |
| cfg_hold | input | NREGION*CW | Per region: write hold cycles |
| cfg_rec_cs | input | NREGION*CW | Per region: idle cycles before another region is selected |
| cfg_rec_rw | input | NREGION*CW | Per region: idle cycles on a direction change |
| cfg_rec_rd | input | NREGION*CW | Per region: idle cycles after a read |
| cfg_rec_wr | input | NREGION*CW | Per region: idle cycles after a write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_addr | input | RSW+EXT_AW-2 | Word address, top RSW bits select the region |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result |
| ext_addr | output | EXT_AW | External address |
| ext_dout | output | 32 | External write data |
| ext_doe | output | 1 | External data drive enable |
| ext_din | input | 32 | External read data |
| ext_cs_n | output | NREGION | Active-low region selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_rw | output | 1 | Direction line, high for read, low for write |
| ext_bc_n | output | 4 | Active-low byte-lane controls |
| ext_wait_n | input | 1 | Active-low external wait |

## Verification
The bench uses the default parameters: four regions, a 24-bit external address and 4-bit counters. This allows each region to be set up differently: one wide with long timing, one narrow, one with wait enabled, and one with large idle counts. Because the counters reach 15, a direction change with a 12-cycle count can be told apart from the 17 cycles a summed policy would give. The small counts in the narrow region make the gap between split halves exact and easy to count.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_CMD,
    ST_STB,
    ST_HOLD,
    ST_DONE
  } amc_state_e;
endpackage

// File: rtl/amc_field_sel.sv
module amc_field_sel #(
  parameter int N  = 4,
  parameter int W  = 4,
  parameter int SW = 2
) (
  input  logic [N*W-1:0] vec,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   val
);
  logic [W-1:0] fields [N];
  for (genvar i = 0; i < N; i++) begin : g_split
    assign fields[i] = vec[i*W +: W];
  end
  assign val = fields[sel];
endmodule

// File: rtl/amc_wait_sync.sv
module amc_wait_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic meta_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_n <= 1'b1;
      sync_n <= 1'b1;
    end else begin
      meta_n <= async_n;
      sync_n <= meta_n;
    end
  end
endmodule

// File: rtl/amc_recovery.sv
module amc_recovery #(
  parameter int CW  = 4,
  parameter int RSW = 2
) (
  input  logic           last_valid,
  input  logic [RSW-1:0] last_region,
  input  logic           last_write,
  input  logic [RSW-1:0] new_region,
  input  logic           new_write,
  input  logic [CW-1:0]  rec_cs,
  input  logic [CW-1:0]  rec_rw,
  input  logic [CW-1:0]  rec_rd,
  input  logic [CW-1:0]  rec_wr,
  output logic [CW-1:0]  need
);
  logic [CW-1:0] base;
  always_comb begin
    base = last_write ? rec_wr : rec_rd;
    need = '0;
    if (last_valid) begin
      need = base;
      if (last_region != new_region && rec_cs > need) need = rec_cs;
      if (last_write != new_write && rec_rw > need) need = rec_rw;
    end
  end
endmodule

// File: rtl/amc_lane.sv
module amc_lane #(
  parameter int EXT_AW = 24
) (
  input  logic              wide,
  input  logic              half,
  input  logic [EXT_AW-3:0] word,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output logic [EXT_AW-1:0] addr,
  output logic [31:0]       dout,
  output logic [3:0]        bc_n
);
  logic [15:0] hw;
  logic [1:0]  hbe;
  assign hw  = half ? wdata[31:16] : wdata[15:0];
  assign hbe = half ? be[3:2] : be[1:0];
  always_comb begin
    if (wide) begin
      addr = {word, 2'b00};
      dout = wdata;
      bc_n = ~be;
    end else begin
      addr = {word, half, 1'b0};
      dout = {hw, hw};
      bc_n = {2'b11, ~hbe};
    end
  end
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int NREGION = 4,
  parameter int EXT_AW  = 24,
  parameter int CW      = 4,
  localparam int RSW    = $clog2(NREGION),
  localparam int IAW    = RSW + EXT_AW - 2,
  localparam int FW     = NREGION * CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREGION-1:0] cfg_wide,
  input  logic [NREGION-1:0] cfg_wait_en,
  input  logic [FW-1:0]      cfg_cmd,
  input  logic [FW-1:0]      cfg_wait,
  input  logic [FW-1:0]      cfg_hold,
  input  logic [FW-1:0]      cfg_rec_cs,
  input  logic [FW-1:0]      cfg_rec_rw,
  input  logic [FW-1:0]      cfg_rec_rd,
  input  logic [FW-1:0]      cfg_rec_wr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IAW-1:0]     req_addr,
  input  logic               req_write,
  input  logic [31:0]        req_wdata,
  input  logic [3:0]         req_be,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic [EXT_AW-1:0]  ext_addr,
  output logic [31:0]        ext_dout,
  output logic               ext_doe,
  input  logic [31:0]        ext_din,
  output logic [NREGION-1:0] ext_cs_n,
  output logic               ext_rd_n,
  output logic               ext_wr_n,
  output logic               ext_rw,
  output logic [3:0]         ext_bc_n,
  input  logic               ext_wait_n
);
  amc_state_e        state;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     idle_cnt;
  logic [EXT_AW-3:0] r_word;
  logic [RSW-1:0]    r_region;
  logic              r_write;
  logic [31:0]       r_wdata;
  logic [3:0]        r_be;
  logic              r_half;
  logic [31:0]       rdata;
  logic              last_valid;
  logic [RSW-1:0]    last_region;
  logic              last_write;
  logic              wait_s_n;

  // settings of the region in progress
  logic [0:0]    cur_wide, cur_wait_en;
  logic [CW-1:0] cur_cmd, cur_wait, cur_hold;
  // idle counts of the region used last
  logic [CW-1:0] lr_cs, lr_rw, lr_rd, lr_wr, need;

  amc_field_sel #(.N(NREGION), .W(1),  .SW(RSW)) u_sel_wide (.vec(cfg_wide),    .sel(r_region), .val(cur_wide));
  amc_field_sel #(.N(NREGION), .W(1),  .SW(RSW)) u_sel_wen  (.vec(cfg_wait_en), .sel(r_region), .val(cur_wait_en));
  amc_field_sel #(.N(NREGION), .W(CW), .SW(RSW)) u_sel_cmd  (.vec(cfg_cmd),     .sel(r_region), .val(cur_cmd));
  amc_field_sel #(.N(NREGION), .W(CW), .SW(RSW)) u_sel_wait (.vec(cfg_wait),    .sel(r_region), .val(cur_wait));
  amc_field_sel #(.N(NREGION), .W(CW), .SW(RSW)) u_sel_hold (.vec(cfg_hold),    .sel(r_region), .val(cur_hold));
  amc_field_sel #(.N(NREGION), .W(CW), .SW(RSW)) u_sel_rcs  (.vec(cfg_rec_cs),  .sel(last_region), .val(lr_cs));
  amc_field_sel #(.N(NREGION), .W(CW), .SW(RSW)) u_sel_rrw  (.vec(cfg_rec_rw),  .sel(last_region), .val(lr_rw));
  amc_field_sel #(.N(NREGION), .W(CW), .SW(RSW)) u_sel_rrd  (.vec(cfg_rec_rd),  .sel(last_region), .val(lr_rd));
  amc_field_sel #(.N(NREGION), .W(CW), .SW(RSW)) u_sel_rwr  (.vec(cfg_rec_wr),  .sel(last_region), .val(lr_wr));

  amc_recovery #(.CW(CW), .RSW(RSW)) u_rec (
    .last_valid(last_valid), .last_region(last_region), .last_write(last_write),
    .new_region(r_region), .new_write(r_write),
    .rec_cs(lr_cs), .rec_rw(lr_rw), .rec_rd(lr_rd), .rec_wr(lr_wr),
    .need(need)
  );

  amc_wait_sync u_wsync (.clk(clk), .rst_n(rst_n), .async_n(ext_wait_n), .sync_n(wait_s_n));

  logic [EXT_AW-1:0] lane_addr;
  logic [31:0]       lane_dout;
  logic [3:0]        lane_bc_n;
  amc_lane #(.EXT_AW(EXT_AW)) u_lane (
    .wide(cur_wide[0]), .half(r_half), .word(r_word), .wdata(r_wdata), .be(r_be),
    .addr(lane_addr), .dout(lane_dout), .bc_n(lane_bc_n)
  );

  logic active, idle_ok, stb_done, cyc_end, skip_lo, skip_hi;
  assign active   = (state == ST_CMD) || (state == ST_STB) || (state == ST_HOLD);
  assign idle_ok  = ({1'b0, idle_cnt} + (CW+1)'(1)) >= {1'b0, need};
  assign stb_done = (state == ST_STB) && (cnt == '0) && !(cur_wait_en[0] && !wait_s_n);
  assign cyc_end  = (stb_done && !(r_write && cur_hold != '0)) ||
                    ((state == ST_HOLD) && (cnt <= CW'(1)));
  assign skip_lo  = !cur_wide[0] && !r_half && (r_be[1:0] == 2'b00);
  assign skip_hi  = !cur_wide[0] && r_half && (r_be[3:2] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      idle_cnt    <= '1;
      r_word      <= '0;
      r_region    <= '0;
      r_write     <= 1'b0;
      r_wdata     <= '0;
      r_be        <= '0;
      r_half      <= 1'b0;
      rdata       <= '0;
      last_valid  <= 1'b0;
      last_region <= '0;
      last_write  <= 1'b0;
    end else begin
      if (active) idle_cnt <= '0;
      else if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;

      case (state)
        ST_IDLE: if (req_valid) begin
          r_region <= req_addr[IAW-1 -: RSW];
          r_word   <= req_addr[EXT_AW-3:0];
          r_write  <= req_write;
          r_wdata  <= req_wdata;
          r_be     <= req_be;
          r_half   <= 1'b0;
          rdata    <= '0;
          state    <= ST_GAP;
        end
        ST_GAP: begin
          if (skip_lo) r_half <= 1'b1;
          else if (skip_hi) state <= ST_DONE;
          else if (idle_ok) begin
            if (cur_cmd == '0) begin
              state <= ST_STB;
              cnt   <= cur_wait;
            end else begin
              state <= ST_CMD;
              cnt   <= cur_cmd;
            end
          end
        end
        ST_CMD: begin
          if (cnt <= CW'(1)) begin
            state <= ST_STB;
            cnt   <= cur_wait;
          end else cnt <= cnt - 1'b1;
        end
        ST_STB: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (stb_done) begin
            if (!r_write) begin
              if (cur_wide[0]) rdata <= ext_din;
              else if (r_half) rdata[31:16] <= ext_din[15:0];
              else rdata[15:0] <= ext_din[15:0];
            end
            if (r_write && cur_hold != '0) begin
              state <= ST_HOLD;
              cnt   <= cur_hold;
            end
          end
        end
        ST_HOLD: if (cnt > CW'(1)) cnt <= cnt - 1'b1;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase

      if (cyc_end) begin
        last_valid  <= 1'b1;
        last_region <= r_region;
        last_write  <= r_write;
        if (!cur_wide[0] && !r_half) begin
          r_half <= 1'b1;
          state  <= ST_GAP;
        end else state <= ST_DONE;
      end
    end
  end

  for (genvar i = 0; i < NREGION; i++) begin : g_cs
    assign ext_cs_n[i] = !(active && (r_region == RSW'(i)));
  end

  assign ext_rd_n  = !((state == ST_STB) && !r_write);
  assign ext_wr_n  = !((state == ST_STB) && r_write);
  assign ext_rw    = active ? !r_write : 1'b1;
  assign ext_doe   = active && r_write;
  assign ext_addr  = active ? lane_addr : '0;
  assign ext_dout  = (active && r_write) ? lane_dout : '0;
  assign ext_bc_n  = active ? lane_bc_n : 4'hF;
  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign rsp_rdata = rdata;
endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
  parameter int NREGION = 4,
  parameter int EXT_AW  = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREGION-1:0] cfg_wide,
  input logic [NREGION-1:0] ext_cs_n,
  input logic               ext_rd_n,
  input logic               ext_wr_n,
  input logic [EXT_AW-1:0]  ext_addr,
  input logic [31:0]        ext_dout,
  input logic [3:0]         ext_bc_n,
  input logic               req_ready,
  input logic               rsp_valid
);
  logic any_cs;
  assign any_cs = (ext_cs_n != '1);

  a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!any_cs && ext_rd_n && ext_wr_n && ext_bc_n == 4'hF));

  a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  a_r3_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> any_cs);

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cs && $rose(ext_wr_n)) |-> ($stable(ext_addr) && $stable(ext_dout) && $stable(ext_cs_n)));

  for (genvar i = 0; i < NREGION; i++) begin : g_narrow
    a_r8_narrow_upper_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_cs_n[i] && !cfg_wide[i]) |-> (ext_bc_n[3:2] == 2'b11));
  end

  a_r11_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind async_mem_ctrl amc_checker #(.NREGION(NREGION), .EXT_AW(EXT_AW)) u_amc_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .ext_cs_n(ext_cs_n),
  .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_addr(ext_addr),
  .ext_dout(ext_dout), .ext_bc_n(ext_bc_n), .req_ready(req_ready),
  .rsp_valid(rsp_valid)
);

// File: tb/tb_async_mem_ctrl.sv
`timescale 1ns/1ps
module tb_async_mem_ctrl;
  localparam int NR = 4, AW = 24, CW = 4, FW = NR*CW, IAW = 2 + AW - 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NR-1:0] cfg_wide = '0, cfg_wait_en = '0;
  logic [FW-1:0] cfg_cmd = '0, cfg_wait = '0, cfg_hold = '0;
  logic [FW-1:0] cfg_rec_cs = '0, cfg_rec_rw = '0, cfg_rec_rd = '0, cfg_rec_wr = '0;
  logic req_valid = 1'b0, req_write = 1'b0, ext_wait_n = 1'b1;
  logic [IAW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, rsp_valid, ext_doe, ext_rd_n, ext_wr_n, ext_rw;
  logic [31:0] rsp_rdata, ext_dout, ext_din;
  logic [AW-1:0] ext_addr;
  logic [NR-1:0] ext_cs_n;
  logic [3:0] ext_bc_n;

  assign ext_din = {~ext_addr[15:0], ext_addr[15:0]};

  async_mem_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_wait_en(cfg_wait_en),
    .cfg_cmd(cfg_cmd), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
    .cfg_rec_cs(cfg_rec_cs), .cfg_rec_rw(cfg_rec_rw), .cfg_rec_rd(cfg_rec_rd),
    .cfg_rec_wr(cfg_rec_wr), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ext_addr(ext_addr),
    .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din), .ext_cs_n(ext_cs_n),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_rw(ext_rw), .ext_bc_n(ext_bc_n),
    .ext_wait_n(ext_wait_n)
  );

  int checks = 0, errors = 0;

  // bus monitor: one record per external cycle
  int ncyc = 0, gap_run = 0;
  bit in_cyc = 0;
  int m_gap[8], m_cmd[8], m_stb[8], m_hold[8];
  logic [AW-1:0] m_addr[8];
  logic [31:0] m_dout[8];
  logic [3:0] m_bc[8];
  logic [NR-1:0] m_cs[8];
  bit m_rw[8], m_wr[8], m_doe[8], m_hold_ok[8];

  always @(negedge clk) begin
    if (rst_n) begin
      if (ext_cs_n == '1) begin
        if (in_cyc) begin
          in_cyc = 0;
          if (ncyc < 7) ncyc++;
        end
        gap_run++;
      end else begin
        if (!in_cyc) begin
          in_cyc = 1;
          m_gap[ncyc] = gap_run; gap_run = 0;
          m_cmd[ncyc] = 0; m_stb[ncyc] = 0; m_hold[ncyc] = 0; m_hold_ok[ncyc] = 1;
        end
        if (!ext_rd_n || !ext_wr_n) begin
          m_stb[ncyc]++;
          m_addr[ncyc] = ext_addr; m_dout[ncyc] = ext_dout; m_bc[ncyc] = ext_bc_n;
          m_cs[ncyc] = ext_cs_n; m_rw[ncyc] = ext_rw; m_wr[ncyc] = !ext_wr_n;
          m_doe[ncyc] = ext_doe;
        end else if (m_stb[ncyc] == 0) m_cmd[ncyc]++;
        else begin
          m_hold[ncyc]++;
          if (ext_addr !== m_addr[ncyc] || ext_dout !== m_dout[ncyc]) m_hold_ok[ncyc] = 0;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_region(input int i, input bit wide, input bit wen,
                            input logic [3:0] cmd, input logic [3:0] wt, input logic [3:0] hold,
                            input logic [3:0] rcs, input logic [3:0] rrw,
                            input logic [3:0] rrd, input logic [3:0] rwr);
    cfg_wide[i] = wide; cfg_wait_en[i] = wen;
    cfg_cmd[i*CW +: CW] = cmd; cfg_wait[i*CW +: CW] = wt; cfg_hold[i*CW +: CW] = hold;
    cfg_rec_cs[i*CW +: CW] = rcs; cfg_rec_rw[i*CW +: CW] = rrw;
    cfg_rec_rd[i*CW +: CW] = rrd; cfg_rec_wr[i*CW +: CW] = rwr;
  endtask

  task automatic send(input logic [1:0] rg, input logic [23:0] a, input bit w,
                      input logic [31:0] wd, input logic [3:0] be);
    ncyc = 0;
    @(negedge clk);
    req_valid = 1; req_addr = {rg, a[23:2]}; req_write = w; req_wdata = wd; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic finish_req(output logic [31:0] rd);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    @(posedge clk); #1;
  endtask

  task automatic do_req(input logic [1:0] rg, input logic [23:0] a, input bit w,
                        input logic [31:0] wd, input logic [3:0] be, output logic [31:0] rd);
    send(rg, a, w, wd, be);
    finish_req(rd);
  endtask

  task automatic t_reset();
    check("R1 ready", {31'b0, req_ready}, 1);
    check("R1 cs", {28'b0, ext_cs_n}, 32'hF);
    check("R1 strobes", {30'b0, ext_rd_n, ext_wr_n}, 3);
    check("R1 bc", {28'b0, ext_bc_n}, 32'hF);
    check("R1 rw/doe/rsp", {29'b0, ext_rw, ext_doe, rsp_valid}, 32'h4);
  endtask

  task automatic t_wide_read();
    logic [31:0] rd;
    ext_wait_n = 0;  // ignored: wait disabled in region 0
    do_req(2'd0, 24'h123456, 0, 0, 4'hF, rd);
    ext_wait_n = 1;
    check("R2 cycles", ncyc, 1);
    check("R2 select", {28'b0, m_cs[0]}, 32'hE);
    check("R7 address", {8'b0, m_addr[0]}, 32'h123454);
    check("R3 cmd delay", m_cmd[0], 2);
    check("R4 strobe length, wait ignored", m_stb[0], 4);
    check("R7 bc", {28'b0, m_bc[0]}, 0);
    check("R7 read data", rd, 32'hCBAB3454);
    check("R11 single pulse", {31'b0, rsp_valid}, 0);
  endtask

  task automatic t_wide_write();
    logic [31:0] rd;
    do_req(2'd0, 24'h000100, 1, 32'hDEADBEEF, 4'b0101, rd);
    check("R6 cycles", ncyc, 1);
    check("R7 dout", m_dout[0], 32'hDEADBEEF);
    check("R7 bc", {28'b0, m_bc[0]}, 32'hA);
    check("R6 rw/wr/doe", {29'b0, m_rw[0], m_wr[0], m_doe[0]}, 32'h3);
    check("R6 hold length", m_hold[0], 2);
    check("R6 hold stable", {31'b0, m_hold_ok[0]}, 1);
  endtask

  task automatic t_split_read();
    logic [31:0] rd;
    do_req(2'd1, 24'h000208, 0, 0, 4'hF, rd);
    check("R8 cycles", ncyc, 2);
    check("R8 first address", {8'b0, m_addr[0]}, 32'h208);
    check("R8 second address", {8'b0, m_addr[1]}, 32'h20A);
    check("R8 bc", {28'b0, m_bc[0]}, 32'hC);
    check("R2 select", {28'b0, m_cs[1]}, 32'hD);
    check("R3 cmd delay", m_cmd[1], 1);
    check("R8 assembled data", rd, 32'h020A0208);
    check("R10 split read gap", m_gap[1], 3);
  endtask

  task automatic t_split_write();
    logic [31:0] rd;
    do_req(2'd1, 24'h000500, 1, 32'h11223344, 4'hF, rd);
    check("R8 cycles", ncyc, 2);
    check("R8 low half", {16'b0, m_dout[0][15:0]}, 32'h3344);
    check("R8 high half", {16'b0, m_dout[1][15:0]}, 32'h1122);
    check("R10 split write gap", m_gap[1], 2);
  endtask

  task automatic t_skips();
    logic [31:0] rd;
    do_req(2'd1, 24'h000300, 1, 32'hCAFE1234, 4'b1100, rd);
    check("R9 upper only cycles", ncyc, 1);
    check("R9 upper only address", {8'b0, m_addr[0]}, 32'h302);
    check("R9 upper only data", {16'b0, m_dout[0][15:0]}, 32'hCAFE);
    check("R9 upper only bc", {28'b0, m_bc[0]}, 32'hC);
    do_req(2'd1, 24'h000400, 0, 0, 4'b0011, rd);
    check("R9 lower only cycles", ncyc, 1);
    check("R9 lower only data", rd, 32'h00000400);
    do_req(2'd1, 24'h000600, 0, 0, 4'b0000, rd);
    check("R9 no cycle", ncyc, 0);
    check("R9 no cycle data", rd, 0);
  endtask

  task automatic t_wait();
    logic [31:0] rd;
    ext_wait_n = 0;
    send(2'd2, 24'h000040, 0, 0, 4'hF);
    while (m_stb[0] < 10 || ncyc != 0) begin
      @(posedge clk); #1;
    end
    check("R11 busy not ready", {31'b0, req_ready}, 0);
    ext_wait_n = 1;
    finish_req(rd);
    check("R5 stretched strobe min", {31'b0, m_stb[0] >= 11}, 1);
    check("R5 strobe ends after release", {31'b0, m_stb[0] <= 15}, 1);
    check("R5 data", rd, 32'hFFBF0040);
  endtask

  task automatic t_recovery();
    logic [31:0] rd;
    do_req(2'd3, 24'h000010, 0, 0, 4'hF, rd);
    do_req(2'd3, 24'h000020, 1, 32'h5, 4'hF, rd);
    check("R10 turnaround gap min", {31'b0, m_gap[0] >= 12}, 1);
    check("R10 largest, not summed", {31'b0, m_gap[0] < 16}, 1);
    do_req(2'd0, 24'h000030, 1, 32'h6, 4'hF, rd);
    check("R10 region change gap min", {31'b0, m_gap[0] >= 7}, 1);
    check("R10 region change gap max", {31'b0, m_gap[0] < 11}, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion (R11)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    set_region(0, 1, 0, 4'd2, 4'd3, 4'd2, 4'd1, 4'd1, 4'd1, 4'd1);
    set_region(1, 0, 0, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1, 4'd3, 4'd2);
    set_region(2, 1, 1, 4'd0, 4'd1, 4'd0, 4'd1, 4'd1, 4'd1, 4'd1);
    set_region(3, 1, 0, 4'd1, 4'd0, 4'd1, 4'd7, 4'd12, 4'd5, 4'd4);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wide_read();
    t_wide_write();
    t_split_read();
    t_split_write();
    t_skips();
    t_wait();
    t_recovery();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule